// File: doc/BRIEF.md
# Dual-Context Event Task Switcher

This block gives one processing core two complete execution contexts, a main one and a secondary one. Each context has its own program counter and its own flag register. A single switch flip-flop selects which context drives the core's fetch address and flag outputs. The core reports each completed instruction together with the next program counter and flag values. The block writes those values into whichever context is active. The inactive context is left unchanged.

Main code programs a secondary start address and chooses one trigger source. The trigger can be a masked pin pattern, an overflow of an internal tick counter, or an equality with the free-running system time. When the chosen event fires, the switch flip-flop sets at the next instruction boundary and the secondary context starts at the programmed address. When the secondary code finishes, it raises the clear input on its last instruction. Control then returns to the main context at exactly the point where it stopped. No state is pushed or popped. An event that arrives while the secondary context is running, or before an instruction boundary, is held as a single pending request.

Top module: `evtask_switcher`

## Requirements
- R1: After reset, act_pc equals RESET_PC (default 0), act_flags is 0, in_secondary is 0 and evt_pending is 0.
- R2: While in_secondary is 0, a cycle with insn_done=1 loads next_pc and next_flags into the main context, and they appear on act_pc and act_flags after that clock edge. A cycle with insn_done=0 leaves both outputs unchanged.
- R3: With trigger mode 1 (pin), an event fires in the cycle where (pins_in & mask) == (value & mask) goes from false to true. A match that stays true does not fire again.
- R4: With trigger mode 2 (overflow), a trigger configuration write loads the tick counter from the reload value. Each cnt_tick increments the counter. A tick taken while the counter is all ones fires an event and reloads the counter, so the first event after a write with reload r comes on tick number 2^CNT_W - r.
- R5: With trigger mode 3 (time), an event fires in the cycle where time_now first equals the match value. A time_now value that holds at the match value does not fire again.
- R6: The secondary context is entered only at a clock edge where insn_done=1 and an event is present or pending. On each entry, act_pc shows the programmed start address, and in_secondary becomes 1.
- R7: While the secondary context runs, the main program counter and flags are kept unchanged. After the return, act_pc and act_flags show the main values saved at entry. The secondary flags are kept from one run of the secondary context to the next.
- R8: The secondary context is left only at an edge where clr_switch=1 and insn_done=1. A clr_switch while in main mode, or a clr_switch without insn_done, has no effect.
- R9: Events that arrive while switched, or between instruction boundaries, set evt_pending. The request is one deep, so several such events collapse into one. It is taken at the first main-context insn_done after the clear.
- R10: With trigger mode 0 (off), no input pattern causes an entry or sets evt_pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start_we | input | 1 | Write strobe for the secondary start address |
| cfg_start_pc | input | PC_W | Secondary start address |
| cfg_trig_we | input | 1 | Write strobe for the trigger configuration |
| cfg_trig_mode | input | 2 | 0 off, 1 pin, 2 overflow, 3 time |
| cfg_pin_mask | input | PIN_W | Pins taking part in the pattern compare |
| cfg_pin_value | input | PIN_W | Pattern expected on the masked pins |
| cfg_cnt_reload | input | CNT_W | Counter reload value |
| cfg_time_match | input | TIME_W | System time compare value |
| pins_in | input | PIN_W | Pin inputs |
| cnt_tick | input | 1 | Counter increment strobe |
| time_now | input | TIME_W | Free-running system time |
| insn_done | input | 1 | Instruction complete, marks an instruction boundary |
| next_pc | input | PC_W | Next program counter of the active context |
| next_flags | input | FLAG_W | Next flags of the active context |
| clr_switch | input | 1 | Secondary code finished, return to main |
| act_pc | output | PC_W | Program counter of the active context |
| act_flags | output | FLAG_W | Flags of the active context |
| in_secondary | output | 1 | Switch flip-flop, 1 while the secondary context runs |
| evt_pending | output | 1 | One-deep pending event request |

## Verification
A wrong switch flip-flop shows up at the next clock edge, because act_pc jumps to the start address or back to a main value in the wrong cycle. A corrupted saved main context stays hidden until the clear, and it then appears as a wrong act_pc or act_flags in the cycle right after the return. Trigger faults show up as an entry one tick early or late in the counter sweep, or as a second entry while a pin or time match is held. A lost or duplicated pending request is seen on evt_pending and as a missing or extra entry at the first main boundary after the clear.

// File: rtl/evtask_pkg.sv
package evtask_pkg;

   typedef enum logic [1:0] {
      TRIG_OFF  = 2'd0,
      TRIG_PIN  = 2'd1,
      TRIG_OVF  = 2'd2,
      TRIG_TIME = 2'd3
   } trig_mode_e;

   localparam int unsigned CTX_MAIN = 0;
   localparam int unsigned CTX_SEC  = 1;
   localparam int unsigned CTX_NUM  = 2;

endpackage

// File: rtl/evtask_trigger.sv
module evtask_trigger
   import evtask_pkg::*;
#(
   parameter int unsigned PIN_W    = 8,
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned TIME_W   = 16,
   parameter bit          PIN_EDGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  trig_mode_e        cfg_mode,
   input  logic [PIN_W-1:0]  cfg_mask,
   input  logic [PIN_W-1:0]  cfg_value,
   input  logic [CNT_W-1:0]  cfg_reload,
   input  logic [TIME_W-1:0] cfg_tmatch,
   input  logic [PIN_W-1:0]  pins_in,
   input  logic              cnt_tick,
   input  logic [TIME_W-1:0] time_now,
   output logic              evt
);

   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   trig_mode_e        mode_q;
   logic [PIN_W-1:0]  mask_q;
   logic [PIN_W-1:0]  value_q;
   logic [CNT_W-1:0]  reload_q;
   logic [TIME_W-1:0] tmatch_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              pin_hit_q;
   logic              time_hit_q;

   logic pin_hit;
   logic pin_evt;
   logic time_hit;
   logic time_evt;
   logic cnt_wrap;

   assign pin_hit  = ((pins_in ^ value_q) & mask_q) == '0;
   assign time_hit = (time_now == tmatch_q);
   assign time_evt = time_hit & ~time_hit_q;
   assign cnt_wrap = cnt_tick & (cnt_q == CNT_TOP);

   generate
      if (PIN_EDGE) begin : g_pin_edge
         assign pin_evt = pin_hit & ~pin_hit_q;

         AST_PIN_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q == TRIG_PIN && evt && !cfg_we) |=> !evt); // R3
      end else begin : g_pin_level
         assign pin_evt = pin_hit;
      end
   endgenerate

   always_comb begin
      unique case (mode_q)
         TRIG_PIN:  evt = pin_evt;
         TRIG_OVF:  evt = cnt_wrap;
         TRIG_TIME: evt = time_evt;
         default:   evt = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q     <= TRIG_OFF;
         mask_q     <= '0;
         value_q    <= '0;
         reload_q   <= '0;
         tmatch_q   <= '0;
         cnt_q      <= '0;
         pin_hit_q  <= 1'b0;
         time_hit_q <= 1'b0;
      end else begin
         pin_hit_q  <= pin_hit;
         time_hit_q <= time_hit;
         if (cfg_we) begin
            mode_q   <= cfg_mode;
            mask_q   <= cfg_mask;
            value_q  <= cfg_value;
            reload_q <= cfg_reload;
            tmatch_q <= cfg_tmatch;
            cnt_q    <= cfg_reload;
         end else if (cnt_tick) begin
            cnt_q <= cnt_wrap ? reload_q : cnt_q + 1'b1;
         end
      end
   end

   AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wrap && !cfg_we) |=> (cnt_q == $past(reload_q))); // R4

   AST_TIME_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == TRIG_TIME && evt && !cfg_we) |=> !evt); // R5

endmodule

// File: rtl/evtask_switch_ctl.sv
module evtask_switch_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic insn_done,
   input  logic clr_switch,
   output logic sw,
   output logic pend,
   output logic enter
);

   logic leave;

   assign enter = ~sw & insn_done & (pend | evt);
   assign leave = sw & insn_done & clr_switch;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sw   <= 1'b0;
         pend <= 1'b0;
      end else begin
         if (enter) begin
            sw   <= 1'b1;
            pend <= pend & evt;
         end else begin
            pend <= pend | evt;
            if (leave) begin
               sw <= 1'b0;
            end
         end
      end
   end

   AST_ENTRY_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw) |-> $past(insn_done)); // R6

   AST_EXIT_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sw) |-> $past(clr_switch && insn_done)); // R8

   AST_PEND_KEPT_WHILE_SWITCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (sw && pend) |=> pend); // R9

endmodule

// File: rtl/evtask_ctx_bank.sv
module evtask_ctx_bank
   import evtask_pkg::*;
#(
   parameter int unsigned PC_W     = 12,
   parameter int unsigned FLAG_W   = 4,
   parameter int unsigned RESET_PC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw,
   input  logic              enter,
   input  logic              insn_done,
   input  logic [PC_W-1:0]   next_pc,
   input  logic [FLAG_W-1:0] next_flags,
   input  logic              start_we,
   input  logic [PC_W-1:0]   start_pc_in,
   output logic [PC_W-1:0]   act_pc,
   output logic [FLAG_W-1:0] act_flags
);

   localparam logic [PC_W-1:0] PC_RST = PC_W'(RESET_PC);

   logic [PC_W-1:0]   start_q;
   logic [PC_W-1:0]   ctx_pc [CTX_NUM];
   logic [FLAG_W-1:0] ctx_fl [CTX_NUM];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
      end else if (start_we) begin
         start_q <= start_pc_in;
      end
   end

   generate
      for (genvar g = 0; g < CTX_NUM; g++) begin : g_ctx
         logic [PC_W-1:0]   pc_q;
         logic [FLAG_W-1:0] fl_q;
         logic              owns;

         assign owns = (g == CTX_SEC) ? sw : ~sw;

         if (g == CTX_SEC) begin : g_sec
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  pc_q <= '0;
                  fl_q <= '0;
               end else if (enter) begin
                  pc_q <= start_q;
               end else if (owns && insn_done) begin
                  pc_q <= next_pc;
                  fl_q <= next_flags;
               end
            end
         end else begin : g_main
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  pc_q <= PC_RST;
                  fl_q <= '0;
               end else if (owns && insn_done) begin
                  pc_q <= next_pc;
                  fl_q <= next_flags;
               end
            end
         end

         assign ctx_pc[g] = pc_q;
         assign ctx_fl[g] = fl_q;
      end
   endgenerate

   assign act_pc    = sw ? ctx_pc[CTX_SEC] : ctx_pc[CTX_MAIN];
   assign act_flags = sw ? ctx_fl[CTX_SEC] : ctx_fl[CTX_MAIN];

   AST_SEC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      enter |=> (ctx_pc[CTX_SEC] == $past(start_q))); // R6

   AST_MAIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      sw |=> ($stable(ctx_pc[CTX_MAIN]) && $stable(ctx_fl[CTX_MAIN]))); // R7

endmodule

// File: rtl/evtask_switcher.sv
module evtask_switcher
   import evtask_pkg::*;
#(
   parameter int unsigned PC_W     = 12,
   parameter int unsigned FLAG_W   = 4,
   parameter int unsigned PIN_W    = 8,
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned TIME_W   = 16,
   parameter int unsigned RESET_PC = 0,
   parameter bit          PIN_EDGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_start_we,
   input  logic [PC_W-1:0]   cfg_start_pc,
   input  logic              cfg_trig_we,
   input  logic [1:0]        cfg_trig_mode,
   input  logic [PIN_W-1:0]  cfg_pin_mask,
   input  logic [PIN_W-1:0]  cfg_pin_value,
   input  logic [CNT_W-1:0]  cfg_cnt_reload,
   input  logic [TIME_W-1:0] cfg_time_match,
   input  logic [PIN_W-1:0]  pins_in,
   input  logic              cnt_tick,
   input  logic [TIME_W-1:0] time_now,
   input  logic              insn_done,
   input  logic [PC_W-1:0]   next_pc,
   input  logic [FLAG_W-1:0] next_flags,
   input  logic              clr_switch,
   output logic [PC_W-1:0]   act_pc,
   output logic [FLAG_W-1:0] act_flags,
   output logic              in_secondary,
   output logic              evt_pending
);

   generate
      if (PC_W < 2 || PC_W > 32) begin : g_bad_pc
         $error("evtask_switcher: PC_W out of range");
      end
      if (FLAG_W < 1) begin : g_bad_flag
         $error("evtask_switcher: FLAG_W must be at least 1");
      end
      if (PIN_W < 1 || CNT_W < 1 || TIME_W < 1) begin : g_bad_evt
         $error("evtask_switcher: event widths must be at least 1");
      end
      if (RESET_PC >= (64'd1 << PC_W)) begin : g_bad_rst
         $error("evtask_switcher: RESET_PC does not fit PC_W");
      end
   endgenerate

   logic evt;
   logic enter;
   logic sw;
   logic pend;

   evtask_trigger #(
      .PIN_W    (PIN_W),
      .CNT_W    (CNT_W),
      .TIME_W   (TIME_W),
      .PIN_EDGE (PIN_EDGE)
   ) u_trig (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_trig_we),
      .cfg_mode   (trig_mode_e'(cfg_trig_mode)),
      .cfg_mask   (cfg_pin_mask),
      .cfg_value  (cfg_pin_value),
      .cfg_reload (cfg_cnt_reload),
      .cfg_tmatch (cfg_time_match),
      .pins_in    (pins_in),
      .cnt_tick   (cnt_tick),
      .time_now   (time_now),
      .evt        (evt)
   );

   evtask_switch_ctl u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (evt),
      .insn_done  (insn_done),
      .clr_switch (clr_switch),
      .sw         (sw),
      .pend       (pend),
      .enter      (enter)
   );

   evtask_ctx_bank #(
      .PC_W     (PC_W),
      .FLAG_W   (FLAG_W),
      .RESET_PC (RESET_PC)
   ) u_ctx (
      .clk         (clk),
      .rst_n       (rst_n),
      .sw          (sw),
      .enter       (enter),
      .insn_done   (insn_done),
      .next_pc     (next_pc),
      .next_flags  (next_flags),
      .start_we    (cfg_start_we),
      .start_pc_in (cfg_start_pc),
      .act_pc      (act_pc),
      .act_flags   (act_flags)
   );

   assign in_secondary = sw;
   assign evt_pending  = pend;

   AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (u_trig.mode_q == TRIG_OFF && !sw && !pend && !cfg_trig_we) |=> !sw); // R10

endmodule

// File: tb/evtask_switcher_test.sv
module evtask_switcher_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_start_we = 1'b0;
   logic [11:0] cfg_start_pc = '0;
   logic        cfg_trig_we = 1'b0;
   logic [1:0]  cfg_trig_mode = '0;
   logic [7:0]  cfg_pin_mask = '0;
   logic [7:0]  cfg_pin_value = '0;
   logic [7:0]  cfg_cnt_reload = '0;
   logic [15:0] cfg_time_match = '0;
   logic [7:0]  pins_in = '0;
   logic        cnt_tick = 1'b0;
   logic [15:0] time_now = 16'hFFFF;
   logic        insn_done = 1'b0;
   logic [11:0] next_pc = '0;
   logic [3:0]  next_flags = '0;
   logic        clr_switch = 1'b0;
   logic [11:0] act_pc;
   logic [3:0]  act_flags;
   logic        in_secondary;
   logic        evt_pending;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   evtask_switcher uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_start_we(cfg_start_we), .cfg_start_pc(cfg_start_pc),
      .cfg_trig_we(cfg_trig_we), .cfg_trig_mode(cfg_trig_mode),
      .cfg_pin_mask(cfg_pin_mask), .cfg_pin_value(cfg_pin_value),
      .cfg_cnt_reload(cfg_cnt_reload), .cfg_time_match(cfg_time_match),
      .pins_in(pins_in), .cnt_tick(cnt_tick), .time_now(time_now),
      .insn_done(insn_done), .next_pc(next_pc), .next_flags(next_flags),
      .clr_switch(clr_switch), .act_pc(act_pc), .act_flags(act_flags),
      .in_secondary(in_secondary), .evt_pending(evt_pending)
   );

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic quiet();
      pins_in = 8'h00; cnt_tick = 1'b0; time_now = 16'hFFFF;
      insn_done = 1'b0; clr_switch = 1'b0;
   endtask

   task automatic set_trig(int mode, int mask, int val, int rel, int tm);
      quiet();
      cfg_trig_we = 1'b1; cfg_trig_mode = 2'(mode); cfg_pin_mask = 8'(mask);
      cfg_pin_value = 8'(val); cfg_cnt_reload = 8'(rel); cfg_time_match = 16'(tm);
      cyc();
      cfg_trig_we = 1'b0;
   endtask

   task automatic do_clear();
      clr_switch = 1'b1; insn_done = 1'b1; next_pc = 12'h3FF; next_flags = 4'h9;
      cyc();
      clr_switch = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      cyc(); cyc();
      chk("R1 pc", int'(act_pc), 0);
      chk("R1 flags", int'(act_flags), 0);
      chk("R1 sec", int'(in_secondary), 0);
      chk("R1 pend", int'(evt_pending), 0);
      rst_n = 1'b1;
      cyc();
      chk("R1 pc after release", int'(act_pc), 0);

      // R2 main stepping
      for (int i = 0; i < 8; i++) begin
         insn_done = 1'b1; next_pc = 12'(16 + 3 * i); next_flags = 4'(i);
         cyc();
         chk("R2 pc", int'(act_pc), 16 + 3 * i);
         chk("R2 flags", int'(act_flags), i);
      end
      insn_done = 1'b0; next_pc = 12'h777; next_flags = 4'hF;
      cyc();
      chk("R2 hold pc", int'(act_pc), 16 + 21);
      chk("R2 hold flags", int'(act_flags), 7);

      cfg_start_we = 1'b1; cfg_start_pc = 12'h200;
      cyc();
      cfg_start_we = 1'b0;

      // R10 mode off
      set_trig(0, 8'h0F, 8'h05, 0, 0);
      for (int i = 0; i < 6; i++) begin
         pins_in = (i % 2 == 1) ? 8'h05 : 8'h00; insn_done = 1'b1;
         cyc();
         chk("R10 sec", int'(in_secondary), 0);
         chk("R10 pend", int'(evt_pending), 0);
      end

      // R3 pin sweep, R6 reload on every entry
      set_trig(1, 8'h0F, 8'h05, 0, 0);
      for (int v = 0; v < 256; v++) begin
         pins_in = 8'hFF; insn_done = 1'b0;
         cyc();
         pins_in = 8'(v); insn_done = 1'b1; next_pc = 12'(v); next_flags = 4'h1;
         cyc();
         chk("R3 pin entry", int'(in_secondary), ((v & 15) == 5) ? 1 : 0);
         if (in_secondary) begin
            chk("R6 reload", int'(act_pc), 12'h200);
            do_clear();
            chk("R3 no retrigger sec", int'(in_secondary), 0);
            chk("R3 no retrigger pend", int'(evt_pending), 0);
            chk("R7 main resume", int'(act_pc), v);
         end
      end

      // R6 entry waits for boundary
      pins_in = 8'h00; insn_done = 1'b1; next_pc = 12'h0AB; next_flags = 4'h6;
      cyc();
      pins_in = 8'h05; insn_done = 1'b0;
      cyc();
      chk("R6 no entry w/o boundary", int'(in_secondary), 0);
      chk("R6 pend latched", int'(evt_pending), 1);
      chk("R6 main held", int'(act_pc), 12'h0AB);
      insn_done = 1'b1; next_pc = 12'h123; next_flags = 4'hA;
      cyc();
      chk("R6 entry", int'(in_secondary), 1);
      chk("R6 start pc", int'(act_pc), 12'h200);
      chk("R7 sec flags kept", int'(act_flags), 9);
      chk("R6 pend consumed", int'(evt_pending), 0);

      // R7 / R8
      pins_in = 8'h00; next_pc = 12'h201; next_flags = 4'h3;
      cyc();
      chk("R7 sec step pc", int'(act_pc), 12'h201);
      chk("R7 sec step flags", int'(act_flags), 3);
      clr_switch = 1'b1; insn_done = 1'b0;
      cyc();
      chk("R8 clr w/o boundary", int'(in_secondary), 1);
      chk("R8 clr w/o boundary pc", int'(act_pc), 12'h201);
      insn_done = 1'b1; next_pc = 12'h202; next_flags = 4'h5;
      cyc();
      chk("R8 left", int'(in_secondary), 0);
      chk("R7 main pc restored", int'(act_pc), 12'h123);
      chk("R7 main flags restored", int'(act_flags), 4'hA);
      clr_switch = 1'b1; insn_done = 1'b0;
      cyc();
      chk("R8 clr in main", int'(in_secondary), 0);
      chk("R8 clr in main pc", int'(act_pc), 12'h123);
      clr_switch = 1'b0;

      // R9 pending collapse
      pins_in = 8'h05; insn_done = 1'b1; next_pc = 12'h150; next_flags = 4'h2;
      cyc();
      chk("R9 enter", int'(in_secondary), 1);
      pins_in = 8'h00; cyc();
      pins_in = 8'h05; cyc();
      chk("R9 pend set", int'(evt_pending), 1);
      pins_in = 8'h00; cyc();
      pins_in = 8'h05; cyc();
      chk("R9 pend one deep", int'(evt_pending), 1);
      pins_in = 8'h00;
      do_clear();
      chk("R9 back to main", int'(in_secondary), 0);
      chk("R9 pend kept", int'(evt_pending), 1);
      chk("R9 main pc", int'(act_pc), 12'h150);
      insn_done = 1'b1; next_pc = 12'h151;
      cyc();
      chk("R9 pend taken", int'(in_secondary), 1);
      chk("R9 pend cleared", int'(evt_pending), 0);
      chk("R9 start pc", int'(act_pc), 12'h200);
      do_clear();
      insn_done = 1'b1; next_pc = 12'h152;
      cyc();
      chk("R9 collapsed", int'(in_secondary), 0);
      chk("R9 collapsed pc", int'(act_pc), 12'h152);

      // R4 counter sweep
      for (int r = 8'hF8; r < 256; r++) begin
         set_trig(2, 0, 0, r, 0);
         for (int round = 0; round < 2; round++) begin
            for (int k = 1; k <= 256 - r; k++) begin
               cnt_tick = 1'b1; insn_done = 1'b1; next_pc = 12'(k);
               cyc();
               chk("R4 ovf entry", int'(in_secondary), (k == 256 - r) ? 1 : 0);
            end
            cnt_tick = 1'b0;
            do_clear();
            chk("R4 cleared", int'(in_secondary), 0);
         end
      end

      // R5 time sweep
      set_trig(3, 0, 0, 0, 16'h0040);
      for (int t = 16'h3C; t <= 16'h44; t++) begin
         time_now = 16'(t); insn_done = 1'b1; next_pc = 12'(t);
         cyc();
         chk("R5 time entry", int'(in_secondary), (t == 16'h40) ? 1 : 0);
         if (in_secondary) begin
            do_clear();
            chk("R5 held no retrigger", int'(evt_pending), 0);
            insn_done = 1'b1;
            cyc();
            chk("R5 held stays main", int'(in_secondary), 0);
         end
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule